// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is one timer channel. A shared prescaler elsewhere in the chip produces a one-cycle tick strobe, and the channel lowers its count by one on each tick while it is enabled. The channel expires when the count is already zero and one more tick arrives, so the count passes below zero. A loaded value N therefore gives a period of N+1 ticks. On expiry the channel can raise a sticky pending flag and emit an interrupt pulse. It then either reloads and keeps counting, or stops.

Software sees three registers: the live count, a reload value and a control/status word. Each register has its own single-cycle write strobe, and all three share one data bus. A write always completes in the cycle its strobe is high. There is no stream interface and no back-pressure: every pin is a plain control or status pin, and the current count and register contents are always present on the outputs.

Control word layout, where a neighbour decodes the bits: bit 0 is enable, bit 1 is auto-restart, bit 2 is load (a command bit that is never stored), bit 3 is interrupt enable and bit 4 is interrupt pending. Bits 5 and 6 are reserved, as are all bits above them.

Top module: `tick_down_timer`

## Requirements
- R1: During and after reset, count_o, reload_o and ctl_o read all zeros and irq_o is low.
- R2: The count drops by one only in a cycle where tick_i is high, enable (bit 0) is set and no counter-changing write occurs. With enable clear, the count holds whatever the tick does.
- R3: Expiry happens on a qualifying tick while the count is 0, so a start value N expires on the (N+1)-th tick. irq_o is high in the cycle after each expiry when interrupt enable (bit 3) was set.
- R4: On expiry with interrupt enable set, pending (bit 4) becomes 1. With interrupt enable clear, expiry sets neither pending nor irq_o, and irq_o is never high while pending is 0.
- R5: On expiry with auto-restart (bit 1) set, the count takes the reload value and counting continues. Without auto-restart, the count becomes all ones and enable clears.
- R6: A control write with bit 4 set clears pending, and a control write with bit 4 clear leaves pending unchanged. If an expiry falls in the same cycle as a clearing write, pending ends up set.
- R7: A control write with load (bit 2) set copies the reload register, as it was before that edge, into the count. This takes priority over a counter write in the same cycle. Load always reads back 0, and counting goes on from the loaded value when enable is set.
- R8: A counter write replaces the count with wr_data_i. A tick in that same cycle is ignored, and counting resumes from the written value when enabled.
- R9: Control readback holds only bits 0, 1, 3 and 4. Bit 2, bits 5 and 6, and every higher bit always read 0, whatever was written.
- R10: A reload write stores wr_data_i, which reads back on reload_o from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaler tick strobe |
| cnt_wr_i | input | 1 | Counter register write strobe |
| rld_wr_i | input | 1 | Reload register write strobe |
| ctl_wr_i | input | 1 | Control register write strobe |
| wr_data_i | input | W | Shared write data |
| count_o | output | W | Current count |
| reload_o | output | W | Reload register readback |
| ctl_o | output | W | Control/status readback |
| irq_o | output | 1 | One-cycle interrupt pulse per expiry |

## Verification
The bench measures the spacing of interrupt pulses with auto-restart on. A design that fires when the count reaches zero instead of when it goes below zero would show a period one tick short. A stopping expiry must leave the count at all ones with enable cleared; a design that wraps and keeps running would keep decrementing. A clearing write in the same cycle as an expiry must leave pending set, and a design that lets software win would lose an interrupt. A load and a counter write in the same cycle must take the reload value. Ticks that coincide with a counter write must not be taken, or the written value would come back one lower.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_AR   = 1;
  localparam int unsigned BIT_LD   = 2;
  localparam int unsigned BIT_IE   = 3;
  localparam int unsigned BIT_PEND = 4;
  localparam int unsigned CTL_USED = 5;

  typedef struct packed {
    logic pend;
    logic ie;
    logic ar;
    logic en;
  } tdt_ctl_t;
endpackage

// File: rtl/tdt_ctl_reg.sv
module tdt_ctl_reg
  import tdt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctl_wr_i,
  input  logic [CTL_USED-1:0] ctl_data_i,
  input  logic                expire_i,
  output tdt_ctl_t            ctl_q_o,
  output logic                load_o
);
  tdt_ctl_t ctl_q;

  assign load_o  = ctl_wr_i & ctl_data_i[BIT_LD];
  assign ctl_q_o = ctl_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      if (ctl_wr_i) begin
        ctl_q.ar <= ctl_data_i[BIT_AR];
        ctl_q.ie <= ctl_data_i[BIT_IE];
      end
      // a stopping expiry overrides any enable written in the same cycle
      if (expire_i && !ctl_q.ar) begin
        ctl_q.en <= 1'b0;
      end else if (ctl_wr_i) begin
        ctl_q.en <= ctl_data_i[BIT_EN];
      end
      // expiry outranks a software clear
      if (expire_i && ctl_q.ie) begin
        ctl_q.pend <= 1'b1;
      end else if (ctl_wr_i && ctl_data_i[BIT_PEND]) begin
        ctl_q.pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic         ar_i,
  input  logic         load_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] count_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         blocked;
  logic         step;

  assign blocked  = load_i | cnt_wr_i;
  assign step     = tick_i & en_i & ~blocked;
  assign expire_o = step & (cnt_q == '0);
  assign count_o  = cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= reload_i;
    end else if (cnt_wr_i) begin
      cnt_q <= wr_data_i;
    end else if (expire_o) begin
      cnt_q <= ar_i ? reload_i : '1;
    end else if (step) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tdt_irq.sv
module tdt_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic ie_i,
  output logic irq_o
);
  logic irq_q;

  assign irq_o = irq_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= expire_i & ie_i;
    end
  end
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tdt_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         cnt_wr_i,
  input  logic         rld_wr_i,
  input  logic         ctl_wr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] reload_o,
  output logic [W-1:0] ctl_o,
  output logic         irq_o
);
  localparam int unsigned PAD_W = W - CTL_USED;

  tdt_ctl_t     ctl_q;
  logic         load;
  logic         expire;
  logic [W-1:0] reload_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      reload_q <= '0;
    end else if (rld_wr_i) begin
      reload_q <= wr_data_i;
    end
  end

  tdt_ctl_reg u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_wr_i   (ctl_wr_i),
    .ctl_data_i (wr_data_i[CTL_USED-1:0]),
    .expire_i   (expire),
    .ctl_q_o    (ctl_q),
    .load_o     (load)
  );

  tdt_counter #(.W(W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .en_i      (ctl_q.en),
    .ar_i      (ctl_q.ar),
    .load_i    (load),
    .cnt_wr_i  (cnt_wr_i),
    .wr_data_i (wr_data_i),
    .reload_i  (reload_q),
    .count_o   (count_o),
    .expire_o  (expire)
  );

  tdt_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .ie_i     (ctl_q.ie),
    .irq_o    (irq_o)
  );

  assign reload_o = reload_q;
  assign ctl_o    = {{PAD_W{1'b0}}, ctl_q.pend, ctl_q.ie, 1'b0, ctl_q.ar, ctl_q.en};
endmodule

// File: rtl/tick_down_timer_chk.sv
module tick_down_timer_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         cnt_wr_i,
  input logic         ctl_wr_i,
  input logic [W-1:0] wr_data_i,
  input logic [W-1:0] count_o,
  input logic [W-1:0] reload_o,
  input logic [W-1:0] ctl_o,
  input logic         irq_o
);
  logic quiet;
  assign quiet = !cnt_wr_i && !(ctl_wr_i && wr_data_i[2]);

  p_hold_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_o[0] && quiet) |=> $stable(count_o));

  p_step_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[0] && tick_i && quiet && count_o != '0) |=> count_o == $past(count_o) - 1'b1);

  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[0] && ctl_o[1] && tick_i && quiet && count_o == '0) |=> count_o == $past(reload_o));

  p_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[0] && !ctl_o[1] && tick_i && quiet && count_o == '0) |=> (!ctl_o[0] && count_o == '1));

  p_pend_with_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctl_o[4]);

  p_quiet_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_o[3] |=> !irq_o);

  p_sticky_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[4] && !(ctl_wr_i && wr_data_i[4])) |=> ctl_o[4]);

  p_load_copy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && wr_data_i[2]) |=> count_o == $past(reload_o));

  p_cnt_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr_i && !(ctl_wr_i && wr_data_i[2])) |=> count_o == $past(wr_data_i));
endmodule

bind tick_down_timer tick_down_timer_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .cnt_wr_i  (cnt_wr_i),
  .ctl_wr_i  (ctl_wr_i),
  .wr_data_i (wr_data_i),
  .count_o   (count_o),
  .reload_o  (reload_o),
  .ctl_o     (ctl_o),
  .irq_o     (irq_o)
);

// File: tb/tick_down_timer_tb_top.sv
module tick_down_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, cw = 1'b0, rw = 1'b0, kw = 1'b0;
  logic [31:0] d = '0;
  logic [31:0] count_o, reload_o, ctl_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tick_down_timer #(.W(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cnt_wr_i(cw), .rld_wr_i(rw),
    .ctl_wr_i(kw), .wr_data_i(d), .count_o(count_o), .reload_o(reload_o),
    .ctl_o(ctl_o), .irq_o(irq_o));

  // behavioural reference model
  logic [31:0] m_cnt = '0, m_rld = '0;
  bit m_en = 0, m_ar = 0, m_ie = 0, m_pd = 0, m_irq = 0;

  always @(posedge clk) begin
    bit blk, stp, ex;
    logic [31:0] ncnt;
    if (!rst_n) begin
      m_cnt = '0; m_rld = '0; m_en = 0; m_ar = 0; m_ie = 0; m_pd = 0; m_irq = 0;
    end else begin
      blk = cw || (kw && d[2]);
      stp = tick && m_en && !blk;
      ex  = stp && (m_cnt == 0);
      if (kw && d[2]) ncnt = m_rld;
      else if (cw) ncnt = d;
      else if (ex) ncnt = m_ar ? m_rld : 32'hFFFF_FFFF;
      else if (stp) ncnt = m_cnt - 1;
      else ncnt = m_cnt;
      m_irq = ex && m_ie;
      if (ex && m_ie) m_pd = 1;
      else if (kw && d[4]) m_pd = 0;
      if (ex && !m_ar) m_en = 0;
      else if (kw) m_en = d[0];
      if (kw) begin m_ar = d[1]; m_ie = d[3]; end
      if (rw) m_rld = d;
      m_cnt = ncnt;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 count", count_o, m_cnt);
      check("R10 reload", reload_o, m_rld);
      check("R9 ctl", ctl_o, {27'd0, m_pd, m_ie, 1'b0, m_ar, m_en});
      check("R3 irq", {31'd0, irq_o}, {31'd0, m_irq});
    end
  end

  task automatic cyc(input bit c, input bit r, input bit k, input bit t, input logic [31:0] v);
    cw = c; rw = r; kw = k; tick = t; d = v;
    @(negedge clk);
    cw = 0; rw = 0; kw = 0; tick = 0; d = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    int first_irq, prev_irq;
    logic [31:0] held;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 count", count_o, 0);
    check("R1 reload", reload_o, 0);
    check("R1 ctl", ctl_o, 0);
    check("R1 irq", {31'd0, irq_o}, 0);
    rst_n = 1;
    @(negedge clk);

    // R10 / R7: reload 5, then load with en|ar|ie
    cyc(0, 1, 0, 0, 32'd5);
    check("R10 reload", reload_o, 5);
    cyc(0, 0, 1, 0, 32'h0F);
    check("R7 load", count_o, 5);
    check("R7 load reads 0", ctl_o, 32'h0B);

    // R3: period is reload+1 ticks
    first_irq = -1; prev_irq = -1;
    for (int i = 0; i < 30; i++) begin
      cyc(0, 0, 0, 1, 0);
      if (irq_o) begin
        if (first_irq < 0) first_irq = i;
        else check("R3 period", i - prev_irq, 6);
        prev_irq = i;
      end
    end
    check("R3 first expiry", first_irq, 5);
    check("R4 pend set", {31'd0, ctl_o[4]}, 1);

    // R6: bit4=0 keeps pending, bit4=1 clears
    cyc(0, 0, 1, 0, 32'h0A);
    check("R6 keep pend", {31'd0, ctl_o[4]}, 1);
    cyc(0, 0, 1, 0, 32'h10);
    check("R6 clear pend", ctl_o, 0);

    // R2: disabled holds
    held = count_o;
    repeat (5) cyc(0, 0, 0, 1, 0);
    check("R2 hold", count_o, held);

    // R8 / R5: counter write then stopping expiry
    cyc(1, 0, 0, 0, 32'd2);
    check("R8 write", count_o, 2);
    cyc(0, 0, 1, 0, 32'h09);
    repeat (3) cyc(0, 0, 0, 1, 0);
    check("R5 stop count", count_o, 32'hFFFF_FFFF);
    check("R5 stop en", {31'd0, ctl_o[0]}, 0);
    check("R4 pend", {31'd0, ctl_o[4]}, 1);
    repeat (3) cyc(0, 0, 0, 1, 0);
    check("R2 stopped hold", count_o, 32'hFFFF_FFFF);

    // R6: expiry beats a same-cycle clear
    cyc(0, 0, 1, 0, 32'h10);
    cyc(1, 0, 0, 0, 32'd0);
    cyc(0, 0, 1, 0, 32'h09);
    cyc(0, 0, 1, 1, 32'h19);
    check("R6 expiry wins", {31'd0, ctl_o[4]}, 1);
    check("R6 irq", {31'd0, irq_o}, 1);

    // R7: load beats counter write
    cyc(0, 1, 0, 0, 32'd100);
    cyc(1, 0, 1, 0, 32'h04);
    check("R7 load priority", count_o, 100);

    // R8: tick during counter write ignored
    cyc(0, 0, 1, 0, 32'h01);
    cyc(1, 0, 0, 1, 32'd50);
    check("R8 tick ignored", count_o, 50);

    // R4: ie off gives no irq, R5 restart reloads
    cyc(0, 0, 1, 0, 32'h13);
    cyc(1, 0, 0, 0, 32'd0);
    cyc(0, 0, 0, 1, 0);
    check("R4 no irq", {31'd0, irq_o}, 0);
    check("R4 no pend", {31'd0, ctl_o[4]}, 0);
    check("R5 restart", count_o, 100);

    // R9: reserved bits read zero
    cyc(0, 0, 1, 0, 32'hFFFF_FFE0);
    check("R9 reserved", ctl_o, 0);

    // mixed traffic, compared per cycle by the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[15:12] == 4'h0)      cyc(0, 1, 0, lfsr[0], {28'd0, lfsr[3:0]});
      else if (lfsr[15:12] == 4'h1) cyc(0, 0, 1, lfsr[0], {27'd0, lfsr[4:0]} | 32'h1);
      else if (lfsr[15:12] == 4'h2) cyc(1, 0, 0, lfsr[0], {29'd0, lfsr[2:0]});
      else                          cyc(0, 0, 0, lfsr[1] | lfsr[5], 0);
    end

    finish_run();
  end
endmodule